// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block records pending interrupt sources sorted into priority levels and decides whether the core should be interrupted. Every level owns a 64-bit source mask. A 32-bit status vector carries one bit per level, and that bit is set while any source of its level is pending. Post and clear commands change single mask bits. A clear-all command empties every level at once. An interrupt-pending output gives the core a quick "something is waiting" hint. The hint is held back while the low two bits of the program counter are non-zero.

When the core raises the evaluate strobe, the block forms a priority and a summary vector. Software request bits in levels 1 to 15 become priorities 1 to 15. Pending external levels 16 to 31 keep their own number as priority and override any software priority. The result is compared with the current priority threshold. If it is higher, the priority and the summary are latched, a one-cycle taken pulse is raised and a valid flag is set. A later update strobe copies the latched values to the summary and identifier outputs and clears the flag. Illegal commands and misplaced strobes raise an error pulse and leave the state untouched.

Top module: `prio_intc`

## Requirements
- R1: A legal post (level below 32, index below 64) sets mask bit `index` of that level and the level's status bit from the next clock edge.
- R2: A legal clear removes mask bit `index` of its level. The status bit of that level drops only when no other bit of that level's mask remains set.
- R3: A clear-all empties every level mask and the status vector at one edge. It overrides any post or clear in the same cycle.
- R4: `irq_pending` is 1 exactly when the status vector is non-zero and `pc[1:0]` is 2'b00.
- R5: A set `sw_req` bit i with 1 <= i <= 15 yields candidate priority i and sets summary bit i, and the highest such bit wins. `sw_req` bits 0 and 16..31 have no effect.
- R6: A set status bit i with 16 <= i <= 31 yields priority i and sets summary bit i. The highest such level wins and overrides every software priority. Status bits 0..15 do not enter the evaluation.
- R7: On `eval`, an interrupt is taken only when the priority is non-zero and strictly greater than `cur_ipl`. One cycle later `int_taken` is 1 for one cycle, and the priority, the summary and the valid flag are latched. A decision that does not take leaves the latched values unchanged. The evaluation uses the status as it stood before that edge.
- R8: `upd` with the valid flag set copies the latched summary to `isr_out` and the latched priority to `intid_out` from the next edge, and clears the flag. If `eval` takes in the same cycle, the flag stays set with the new values. Otherwise `isr_out` and `intid_out` hold.
- R9: `err` is 1 for one cycle after an edge that saw any of three things: a post or clear with level >= 32 or index >= 64, or `upd` while the valid flag is clear. The rejected command changes no mask, status, output or latched value.
- R10: A post and a clear aimed at the same level and index in one cycle leave the bit set. Aimed at different targets, both take effect.
- R11: After reset every mask, the status vector, the latched values, the valid flag and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Post command strobe |
| post_lvl | input | 6 | Post level (values >= 32 illegal) |
| post_idx | input | 7 | Post source index (values >= 64 illegal) |
| clr_en | input | 1 | Clear command strobe |
| clr_lvl | input | 6 | Clear level |
| clr_idx | input | 7 | Clear source index |
| clr_all | input | 1 | Empty all levels |
| pc | input | 32 | Current program counter |
| sw_req | input | 32 | Software interrupt request bits |
| cur_ipl | input | 5 | Current priority threshold |
| eval | input | 1 | Evaluate strobe |
| upd | input | 1 | Update strobe |
| irq_pending | output | 1 | Status non-zero and PC aligned |
| int_taken | output | 1 | Pulse: evaluation took an interrupt |
| isr_out | output | 32 | Delivered summary vector |
| intid_out | output | 5 | Delivered priority |
| err | output | 1 | Pulse: illegal command or update |

## Verification
Every registered result (`int_taken`, `err`, `isr_out`, `intid_out`) is due one edge after the edge that samples its stimulus. `irq_pending` follows the status registers, so it reflects a post or clear straight after the same edge. The bench drives inputs at the falling edge, advances its reference model at that point, and compares all five outputs at the next falling edge, once every register involved has settled. Directed sequences cover threshold equality, post-versus-clear collisions, partially emptied levels, misaligned PCs and illegal commands. Seeded random traffic covers the rest.

// File: rtl/prio_intc_pkg.sv
// Package: shared defaults and the software-level priority mapping.
// Assumes levels are numbered from 0 and priorities fit in clog2(levels) bits.
package prio_intc_pkg;
    localparam int unsigned LEVELS_DEF = 32;
    localparam int unsigned SRCS_DEF   = 64;
    localparam int unsigned PC_W_DEF   = 32;

    // Map a software request bit position to its priority number.
    function automatic int unsigned sw_bit_to_prio(input int unsigned bitpos,
                                                   input int unsigned sw_lo);
        return bitpos - sw_lo + 1;
    endfunction
endpackage

// File: rtl/intc_level_bank.sv
// Level bank: one pending-source mask and one status flop per level.
// Assumes post/clear qualifiers are already range-checked by the parent,
// so only the low index bits are used to address a mask bit.
module intc_level_bank #(
    parameter int unsigned NUM_LEVELS = 32,
    parameter int unsigned NUM_SRCS   = 64,
    parameter int unsigned LVL_FW     = 6,
    parameter int unsigned IDX_FW     = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 post_ok,
    input  logic [LVL_FW-1:0]                    post_lvl,
    input  logic [IDX_FW-1:0]                    post_idx,
    input  logic                                 clr_ok,
    input  logic [LVL_FW-1:0]                    clr_lvl,
    input  logic [IDX_FW-1:0]                    clr_idx,
    input  logic                                 clr_all,
    output logic [NUM_LEVELS-1:0][NUM_SRCS-1:0]  mask_q,
    output logic [NUM_LEVELS-1:0]                status_q
);
    localparam int unsigned BIT_W = $clog2(NUM_SRCS);

    logic [BIT_W-1:0] post_bit;
    logic [BIT_W-1:0] clr_bit;
    assign post_bit = post_idx[BIT_W-1:0];
    assign clr_bit  = clr_idx[BIT_W-1:0];

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
        logic                hit_post;
        logic                hit_clr;
        logic [NUM_SRCS-1:0] mask_r;
        logic [NUM_SRCS-1:0] mask_n;
        logic                stat_r;

        assign hit_post = post_ok && (post_lvl == LVL_FW'(l));
        assign hit_clr  = clr_ok  && (clr_lvl  == LVL_FW'(l));

        // Next mask: clear first, then post, so a same-bit post wins.
        always_comb begin
            mask_n = mask_r;
            if (hit_clr)  mask_n[clr_bit]  = 1'b0;
            if (hit_post) mask_n[post_bit] = 1'b1;
        end

        // Mask and status registers for this level.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                mask_r <= '0;
                stat_r <= 1'b0;
            end else begin
                mask_r <= mask_n;
                if (hit_post)
                    stat_r <= 1'b1;
                else if (hit_clr && (mask_n == '0))
                    stat_r <= 1'b0;
            end
        end

        assign mask_q[l]   = mask_r;
        assign status_q[l] = stat_r;
    end
endmodule

// File: rtl/intc_prio_eval.sv
// Priority evaluator: combines software requests and external status
// into a priority and a summary, and decides against the threshold.
// Assumes the external range lies above the software range, so a later
// (external) hit overrides an earlier (software) one.
module intc_prio_eval
    import prio_intc_pkg::*;
#(
    parameter int unsigned NUM_LEVELS = 32,
    parameter int unsigned SW_LO      = 1,
    parameter int unsigned SW_HI      = 15,
    parameter int unsigned EXT_LO     = 16,
    parameter int unsigned EXT_HI     = 31,
    parameter int unsigned PRIO_W     = 5
) (
    input  logic [NUM_LEVELS-1:0] status,
    input  logic [NUM_LEVELS-1:0] sw_req,
    input  logic [PRIO_W-1:0]     cur_ipl,
    input  logic                  eval,
    output logic [PRIO_W-1:0]     prio_c,
    output logic [NUM_LEVELS-1:0] summ_c,
    output logic                  take_c
);
    // Scan software bits, then external levels; the last hit sets the priority.
    always_comb begin
        prio_c = '0;
        summ_c = '0;
        for (int unsigned i = SW_LO; i <= SW_HI; i++) begin
            if (sw_req[i]) begin
                prio_c    = PRIO_W'(sw_bit_to_prio(i, SW_LO));
                summ_c[i] = 1'b1;
            end
        end
        for (int unsigned i = EXT_LO; i <= EXT_HI; i++) begin
            if (status[i]) begin
                prio_c    = PRIO_W'(i);
                summ_c[i] = 1'b1;
            end
        end
    end

    // Take only a non-zero priority strictly above the threshold.
    assign take_c = eval && (prio_c != '0) && (prio_c > cur_ipl);
endmodule

// File: rtl/intc_deliver.sv
// Delivery stage: latches a taken decision and hands it to the output
// registers on the update strobe. Assumes take_c is already qualified by eval.
module intc_deliver #(
    parameter int unsigned NUM_LEVELS = 32,
    parameter int unsigned PRIO_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_c,
    input  logic [PRIO_W-1:0]     prio_c,
    input  logic [NUM_LEVELS-1:0] summ_c,
    input  logic                  upd,
    output logic                  int_taken,
    output logic [NUM_LEVELS-1:0] isr_out,
    output logic [PRIO_W-1:0]     intid_out,
    output logic                  valid_q,
    output logic                  upd_bad
);
    logic [PRIO_W-1:0]     lat_prio;
    logic [NUM_LEVELS-1:0] lat_summ;

    assign upd_bad = upd && !valid_q;

    // Latch decisions, deliver on update, maintain the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_taken <= 1'b0;
            lat_prio  <= '0;
            lat_summ  <= '0;
            valid_q   <= 1'b0;
            isr_out   <= '0;
            intid_out <= '0;
        end else begin
            int_taken <= take_c;
            if (upd && valid_q) begin
                isr_out   <= lat_summ;
                intid_out <= lat_prio;
            end
            if (take_c) begin
                lat_prio <= prio_c;
                lat_summ <= summ_c;
                valid_q  <= 1'b1;
            end else if (upd) begin
                valid_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Top: range-checks commands, holds the level bank, evaluates priority
// and delivers the result. Illegal commands are dropped and flagged on err.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int unsigned NUM_LEVELS = LEVELS_DEF,
    parameter int unsigned NUM_SRCS   = SRCS_DEF,
    parameter int unsigned PC_W       = PC_W_DEF,
    parameter int unsigned SW_LO      = 1,
    parameter int unsigned SW_HI      = 15,
    parameter int unsigned EXT_LO     = 16,
    parameter int unsigned EXT_HI     = 31,
    localparam int unsigned LVL_FW    = $clog2(NUM_LEVELS) + 1,
    localparam int unsigned IDX_FW    = $clog2(NUM_SRCS) + 1,
    localparam int unsigned PRIO_W    = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_en,
    input  logic [LVL_FW-1:0]     post_lvl,
    input  logic [IDX_FW-1:0]     post_idx,
    input  logic                  clr_en,
    input  logic [LVL_FW-1:0]     clr_lvl,
    input  logic [IDX_FW-1:0]     clr_idx,
    input  logic                  clr_all,
    input  logic [PC_W-1:0]       pc,
    input  logic [NUM_LEVELS-1:0] sw_req,
    input  logic [PRIO_W-1:0]     cur_ipl,
    input  logic                  eval,
    input  logic                  upd,
    output logic                  irq_pending,
    output logic                  int_taken,
    output logic [NUM_LEVELS-1:0] isr_out,
    output logic [PRIO_W-1:0]     intid_out,
    output logic                  err
);
    logic post_legal, clr_legal, post_ok, clr_ok, upd_bad, valid_q, take_c;
    logic [NUM_LEVELS-1:0][NUM_SRCS-1:0] mask_q;
    logic [NUM_LEVELS-1:0]               status_q;
    logic [PRIO_W-1:0]                   prio_c;
    logic [NUM_LEVELS-1:0]               summ_c;

    assign post_legal = (post_lvl < LVL_FW'(NUM_LEVELS)) && (post_idx < IDX_FW'(NUM_SRCS));
    assign clr_legal  = (clr_lvl  < LVL_FW'(NUM_LEVELS)) && (clr_idx  < IDX_FW'(NUM_SRCS));
    assign post_ok    = post_en && post_legal;
    assign clr_ok     = clr_en  && clr_legal;

    intc_level_bank #(
        .NUM_LEVELS(NUM_LEVELS), .NUM_SRCS(NUM_SRCS),
        .LVL_FW(LVL_FW), .IDX_FW(IDX_FW)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .post_ok(post_ok), .post_lvl(post_lvl), .post_idx(post_idx),
        .clr_ok(clr_ok), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
        .clr_all(clr_all), .mask_q(mask_q), .status_q(status_q)
    );

    intc_prio_eval #(
        .NUM_LEVELS(NUM_LEVELS), .SW_LO(SW_LO), .SW_HI(SW_HI),
        .EXT_LO(EXT_LO), .EXT_HI(EXT_HI), .PRIO_W(PRIO_W)
    ) u_eval (
        .status(status_q), .sw_req(sw_req), .cur_ipl(cur_ipl), .eval(eval),
        .prio_c(prio_c), .summ_c(summ_c), .take_c(take_c)
    );

    intc_deliver #(
        .NUM_LEVELS(NUM_LEVELS), .PRIO_W(PRIO_W)
    ) u_deliver (
        .clk(clk), .rst_n(rst_n), .take_c(take_c), .prio_c(prio_c),
        .summ_c(summ_c), .upd(upd), .int_taken(int_taken),
        .isr_out(isr_out), .intid_out(intid_out), .valid_q(valid_q),
        .upd_bad(upd_bad)
    );

    // Core hint: something pending and the PC is on an aligned boundary.
    assign irq_pending = (status_q != '0) && (pc[1:0] == 2'b00);

    // Error pulse for rejected commands and misplaced update strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else
            err <= (post_en && !post_legal) || (clr_en && !clr_legal) || upd_bad;
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Checker for prio_intc, bound to the top. Observes ports and the
// status, mask and valid state that separate submodules drive.
module prio_intc_chk #(
    parameter int unsigned NUM_LEVELS = 32,
    parameter int unsigned NUM_SRCS   = 64,
    parameter int unsigned PC_W       = 32
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                clr_all,
    input logic                                eval,
    input logic                                upd,
    input logic [PC_W-1:0]                     pc,
    input logic                                irq_pending,
    input logic                                int_taken,
    input logic [NUM_LEVELS-1:0]               isr_out,
    input logic                                err,
    input logic                                valid_q,
    input logic [NUM_LEVELS-1:0]               status_q,
    input logic [NUM_LEVELS-1:0][NUM_SRCS-1:0] mask_q
);
    logic [NUM_LEVELS-1:0] any_bit;
    always_comb begin
        for (int l = 0; l < NUM_LEVELS; l++) any_bit[l] = |mask_q[l];
    end

    // R2
    status_mask_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q == any_bit);

    // R3
    clear_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (status_q == '0));

    // R4
    pending_needs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> ((pc[1:0] == 2'b00) && (status_q != '0)));

    // R7
    taken_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_taken |-> ($past(eval) && valid_q));

    // R8
    isr_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd) |-> $stable(isr_out));

    // R9
    bad_update_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !valid_q) |=> err);
endmodule

bind prio_intc prio_intc_chk #(
    .NUM_LEVELS(NUM_LEVELS), .NUM_SRCS(NUM_SRCS), .PC_W(PC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .eval(eval), .upd(upd),
    .pc(pc), .irq_pending(irq_pending), .int_taken(int_taken),
    .isr_out(isr_out), .err(err), .valid_q(valid_q),
    .status_q(status_q), .mask_q(mask_q)
);

// File: tb/prio_intc_tb.sv
// Bench for prio_intc: directed corner cases then seeded random traffic,
// checked each cycle against a reference model kept in the bench.
module prio_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_en = 0, clr_en = 0, clr_all = 0, eval = 0, upd = 0;
    logic [5:0]  post_lvl = 0, clr_lvl = 0;
    logic [6:0]  post_idx = 0, clr_idx = 0;
    logic [31:0] pc = 0, sw_req = 0;
    logic [4:0]  cur_ipl = 0;
    logic        irq_pending, int_taken, err;
    logic [31:0] isr_out;
    logic [4:0]  intid_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [63:0] m_mask [32];
    logic [31:0] m_isr = 0, m_summ = 0;
    logic [4:0]  m_id = 0, m_prio = 0;
    logic        m_valid = 0, m_taken = 0, m_err = 0;

    always #5 clk = ~clk;

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_lvl(post_lvl),
        .post_idx(post_idx), .clr_en(clr_en), .clr_lvl(clr_lvl),
        .clr_idx(clr_idx), .clr_all(clr_all), .pc(pc), .sw_req(sw_req),
        .cur_ipl(cur_ipl), .eval(eval), .upd(upd),
        .irq_pending(irq_pending), .int_taken(int_taken),
        .isr_out(isr_out), .intid_out(intid_out), .err(err)
    );

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        for (int l = 0; l < 32; l++) s[l] = (m_mask[l] != 64'd0);
        return s;
    endfunction

    // Expected {summary, priority} from the requirements (R5, R6).
    function automatic logic [36:0] ref_eval(logic [31:0] st, logic [31:0] sw);
        logic [4:0]  p = 0;
        logic [31:0] s = 0;
        for (int i = 1; i <= 15; i++) if (sw[i]) begin p = 5'(i); s[i] = 1'b1; end
        for (int i = 16; i <= 31; i++) if (st[i]) begin p = 5'(i); s[i] = 1'b1; end
        return {s, p};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance the model for the inputs now driven, clock once, compare.
    task automatic cycle(string ctx);
        logic [36:0] r;
        logic        take, pl, cl;
        pl = (post_lvl < 32) && (post_idx < 64);
        cl = (clr_lvl < 32) && (clr_idx < 64);
        r = ref_eval(m_status(), sw_req);
        take = eval && (r[4:0] != 0) && (r[4:0] > cur_ipl);
        m_err = (post_en && !pl) || (clr_en && !cl) || (upd && !m_valid);
        m_taken = take;
        if (upd && m_valid) begin m_isr = m_summ; m_id = m_prio; m_valid = 0; end
        if (take) begin m_prio = r[4:0]; m_summ = r[36:5]; m_valid = 1; end
        if (clr_all) begin
            for (int l = 0; l < 32; l++) m_mask[l] = 0;
        end else begin
            if (clr_en && cl)  m_mask[clr_lvl[4:0]][clr_idx[5:0]] = 1'b0;
            if (post_en && pl) m_mask[post_lvl[4:0]][post_idx[5:0]] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        chk({ctx, " R4 irq_pending"}, 64'(irq_pending),
            64'((m_status() != 0) && (pc[1:0] == 2'b00)));
        chk({ctx, " R7 int_taken"}, 64'(int_taken), 64'(m_taken));
        chk({ctx, " R9 err"}, 64'(err), 64'(m_err));
        chk({ctx, " R8 isr_out"}, 64'(isr_out), 64'(m_isr));
        chk({ctx, " R8 intid_out"}, 64'(intid_out), 64'(m_id));
    endtask

    task automatic idle();
        post_en = 0; clr_en = 0; clr_all = 0; eval = 0; upd = 0;
    endtask

    task automatic do_post(int l, int i);
        post_en = 1; post_lvl = 6'(l); post_idx = 7'(i);
    endtask

    task automatic do_clr(int l, int i);
        clr_en = 1; clr_lvl = 6'(l); clr_idx = 7'(i);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 32; l++) m_mask[l] = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state (pc aligned, so pending would show any status)
        chk("R11 irq_pending", 64'(irq_pending), 0);
        chk("R11 int_taken", 64'(int_taken), 0);
        chk("R11 isr_out", 64'(isr_out), 0);
        chk("R11 intid_out", 64'(intid_out), 0);
        chk("R11 err", 64'(err), 0);

        // R1: post on external level 20, top index
        do_post(20, 63); cycle("R1"); idle();
        // R4: misaligned PC hides pending
        pc = 32'h1001; cycle("R4"); pc = 32'h1002; cycle("R4"); pc = 32'h1000;
        // R2: second bit, clear one, level stays; clear last, level drops
        do_post(20, 5); cycle("R2"); idle();
        do_clr(20, 63); cycle("R2"); idle();
        eval = 1; cur_ipl = 5'd19; cycle("R2 R6 eval"); idle();
        upd = 1; cycle("R8 upd"); idle();
        do_clr(20, 5); cycle("R2 empty"); idle();
        // R9: update with valid clear is an error and changes nothing
        upd = 1; cycle("R9 upd"); idle();
        // R9: out-of-range level and index rejected
        do_post(32, 0); cycle("R9 lvl"); idle();
        do_post(3, 64); cycle("R9 idx"); idle();
        do_clr(40, 100); cycle("R9 clr"); idle();
        // R5: software mapping, bits 0 and 16+ ignored, highest wins
        sw_req = 32'h0001_0000 | 32'h1 | 32'h0000_0120; cur_ipl = 0;
        eval = 1; cycle("R5 sw"); idle(); upd = 1; cycle("R5 upd"); idle();
        sw_req = 32'h8001_0001; eval = 1; cycle("R5 none"); idle();
        // R7: threshold equal to priority is not taken
        sw_req = 32'h0000_0100; cur_ipl = 5'd8; eval = 1; cycle("R7 eq"); idle();
        cur_ipl = 5'd7; eval = 1; cycle("R7 gt"); idle();
        // R6: external overrides software; software-range status ignored
        do_post(2, 1); cycle("R6 sw-level"); idle();
        do_post(17, 0); sw_req = 32'h0000_4002; cycle("R6"); idle();
        eval = 1; cur_ipl = 0; upd = 1; cycle("R6 R8 same"); idle();
        upd = 1; cycle("R8"); idle();
        // R10: post wins over same-target clear; different targets both act
        do_post(25, 9); do_clr(25, 9); cycle("R10 same"); idle();
        do_post(26, 1); do_clr(17, 0); cycle("R10 diff"); idle();
        eval = 1; cycle("R10 eval"); idle(); upd = 1; cycle("R10 upd"); idle();
        // R3: clear-all beats a post in the same cycle
        do_post(30, 2); clr_all = 1; cycle("R3"); idle();
        eval = 1; sw_req = 0; cycle("R3 eval"); idle();

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            post_en  = ($urandom % 2) == 0;
            post_lvl = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 32);
            post_idx = ($urandom % 10 == 0) ? 7'($urandom % 128) : 7'($urandom % 6);
            clr_en   = ($urandom % 2) == 0;
            clr_lvl  = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 32);
            clr_idx  = ($urandom % 10 == 0) ? 7'($urandom % 128) : 7'($urandom % 6);
            clr_all  = ($urandom % 50) == 0;
            pc       = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFF_FFFC);
            sw_req   = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'h0;
            cur_ipl  = 5'($urandom % 32);
            eval     = ($urandom % 3) == 0;
            upd      = ($urandom % 3) == 0;
            cycle("R1 R2 R5 R6 R7 R8 R10 random");
        end
        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule